// File: doc/BRIEF.md
# Card Clock Divider with Drive and Sample Phase Taps

This block runs from a fast parent clock and produces an integer-divided card clock for a memory-card bus. It also produces two companion clocks at the same frequency. The drive clock times when data is launched onto the bus. The sample clock times when data is captured from it. All three outputs are registered in the parent-clock domain.

A single 32-bit control register holds three settings: the divide ratio, one 3-bit phase code for each companion clock, and a gate enable. A phase code of zero gives a companion clock that is the card clock inverted, which is a half-period shift. A nonzero code N places the companion clock N parent cycles behind the card clock. The card clock's own phase is never moved.

Register writes are stored at once. The divider only adopts the new settings when a card-clock period begins, so a period that is already running finishes with the settings it started with. The register port and the clock outputs are plain control pins, with no valid/ready handshake. A write is accepted on every cycle in which the write strobe is high, so there is no back-pressure.

Top module: `cardclk_phase_gen`

## Requirements
- R1: After reset the control register reads 0x00000000 and the card, drive and sample outputs are all low.
- R2: With ratio field value F in bits [3:0], the card clock period is F+1 parent cycles and each rising edge starts a period. With F = 0 the card clock stays high while it is enabled.
- R3: The card clock is high for ceil(R/2) parent cycles and low for floor(R/2) parent cycles, where R = F+1. For odd R the high phase is therefore one cycle longer.
- R4: A phase code of 0 makes the companion clock the inverse of the card clock while the clock is running. It is low in the first cycle after start-up.
- R5: A nonzero phase code N makes the companion clock equal to the card clock delayed by N parent cycles. Before the delayed waveform arrives, the companion clock is low.
- R6: A nonzero code N with N >= R uses a delay of N mod R. When that result is 0, the companion clock equals the card clock.
- R7: While bit 31 is 0, all three outputs settle low. When bit 31 is written to 1 from the idle state, the card clock first rises on the second parent edge after the write edge, and both companion clocks run from that same period.
- R8: The fields are: bits [3:0] hold the ratio, bits [10:8] the drive phase code, bits [22:20] the sample phase code, and bit 31 the enable. A read returns exactly the 32 bits last written, including bits that no field uses.
- R9: A write made during a running period takes effect at the first card-period boundary after the write. The period in progress completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| par_clk_i | input | 1 | Fast parent clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_en_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 32 | Control register write data |
| cfg_rdata_o | output | 32 | Control register read data |
| card_clk_o | output | 1 | Divided card clock |
| drv_clk_o | output | 1 | Drive-timing companion clock |
| smp_clk_o | output | 1 | Sample-timing companion clock |

## Verification
A write that enables the clock from idle is stored on its own edge. The run state is loaded one edge later, and the registered card output rises on the following edge. The first due sample is therefore the one after write edge plus one, which must still read all low. Card-clock sample k (k = 0, 1, 2, ...) is due after write edge plus 2 + k, and a companion clock with delay d follows the card clock by d more edges. The bench pushes the whole expected per-cycle sequence into a queue before the first edge that could change an output. A monitor pops one entry two nanoseconds after each rising edge, so every comparison falls on the cycle in which the result is due. For a write made while the clock is running, the expected sequence switches ratio at the first boundary after the write, and the bench makes that write on a fixed edge.

// File: rtl/clkph_pkg.sv
package clkph_pkg;

  // Register layout
  parameter int unsigned REG_W     = 32;
  parameter int unsigned DIV_W     = 4;
  parameter int unsigned PH_W      = 3;
  parameter int unsigned NTAPS     = 2;
  parameter int unsigned EN_BIT    = 31;
  parameter int unsigned RATIO_LSB = 0;

  // Derived sizes
  localparam int unsigned HIST_D = (1 << PH_W) - 1;
  localparam int unsigned CNT_W  = DIV_W + 1;

  typedef logic [PH_W-1:0] code_t;

  typedef struct packed {
    logic                        en;
    logic [DIV_W-1:0]            ratio_m1;
    logic [NTAPS-1:0][PH_W-1:0]  code;
  } cfg_t;

  // Bit position of the phase field for tap i (0 = drive, 1 = sample)
  function automatic int unsigned tap_lsb(input int unsigned idx);
    return (idx == 0) ? 8 : 20;
  endfunction

  // Nonzero code reduced modulo the ratio by repeated subtraction
  function automatic code_t phase_wrap(input code_t code,
                                       input logic [CNT_W-1:0] ratio);
    logic [CNT_W-1:0] rem;
    rem = {{(CNT_W-PH_W){1'b0}}, code};
    for (int i = 0; i < (1 << PH_W); i++) begin
      if (rem >= ratio) rem = rem - ratio;
    end
    return rem[PH_W-1:0];
  endfunction

endpackage

// File: rtl/clkph_ctrl_reg.sv
module clkph_ctrl_reg
  import clkph_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output cfg_t             cfg_o
);

  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wdata_i;
  end

  assign rdata_o = ctrl_q;

  always_comb begin
    cfg_o.en       = ctrl_q[EN_BIT];
    cfg_o.ratio_m1 = ctrl_q[RATIO_LSB +: DIV_W];
    for (int t = 0; t < NTAPS; t++) begin
      cfg_o.code[t] = ctrl_q[tap_lsb(t) +: PH_W];
    end
  end

  // R8: a write is visible on the read port right after its edge
  assert_readback_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rdata_o == $past(wdata_i)));

endmodule

// File: rtl/clkph_div_core.sv
module clkph_div_core
  import clkph_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  cfg_t                       cfg_i,
  output logic                       run_o,
  output logic                       card_nxt_o,
  output logic                       card_o,
  output logic [NTAPS-1:0]           inv_o,
  output logic [NTAPS-1:0][PH_W-1:0] dly_o
);

  logic [DIV_W-1:0]            cnt_q;
  logic [DIV_W-1:0]            m1_q;
  logic [CNT_W-1:0]            half_q;
  logic                        run_q;
  logic                        card_q;
  logic [NTAPS-1:0]            inv_q;
  logic [NTAPS-1:0][PH_W-1:0]  dly_q;
  logic                        boundary;
  logic [CNT_W-1:0]            ratio_new;

  // Settings are adopted when idle or when the last cycle of a period ends
  assign boundary  = !run_q || (cnt_q == m1_q);
  assign ratio_new = {1'b0, cfg_i.ratio_m1} + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      m1_q   <= '0;
      half_q <= CNT_W'(1);
      run_q  <= 1'b0;
      inv_q  <= '1;
      dly_q  <= '0;
    end else if (boundary) begin
      cnt_q  <= '0;
      m1_q   <= cfg_i.ratio_m1;
      half_q <= (ratio_new + CNT_W'(1)) >> 1;
      run_q  <= cfg_i.en;
      for (int t = 0; t < NTAPS; t++) begin
        inv_q[t] <= (cfg_i.code[t] == '0);
        dly_q[t] <= phase_wrap(cfg_i.code[t], ratio_new);
      end
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign card_nxt_o = run_q && ({1'b0, cnt_q} < half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) card_q <= 1'b0;
    else         card_q <= card_nxt_o;
  end

  assign run_o  = run_q;
  assign card_o = card_q;
  assign inv_o  = inv_q;
  assign dly_o  = dly_q;

  // R2: the counter never leaves the active period
  assert_cnt_in_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= m1_q);

  // R2: card rising edges only start a period
  assert_rise_on_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_q) |-> ($past(cnt_q) == '0));

  // R7: card clock stays low while gated
  assert_gate_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !card_q);

  // R9: active ratio held until the period finishes
  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && (cnt_q != m1_q)) |=> ($stable(m1_q) && $stable(half_q)));

endmodule

// File: rtl/clkph_tap.sv
module clkph_tap
  import clkph_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  card_nxt_i,
  input  logic  inv_i,
  input  code_t dly_i,
  output logic  tap_o
);

  logic [HIST_D-1:0] hist_q;
  logic              sel;
  logic              tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[HIST_D-2:0], card_nxt_i};
  end

  always_comb begin
    if (inv_i)             sel = run_i && !card_nxt_i;
    else if (dly_i == '0)  sel = card_nxt_i;
    else                   sel = hist_q[dly_i - code_t'(1)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= 1'b0;
    else         tap_q <= sel;
  end

  assign tap_o = tap_q;

  // R7: once gated and the history has drained, the tap stays low
  assert_tap_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && (hist_q == '0)) |=> !tap_q);

endmodule

// File: rtl/cardclk_phase_gen.sv
module cardclk_phase_gen
  import clkph_pkg::*;
(
  input  logic        par_clk_i,
  input  logic        rst_ni,
  input  logic        cfg_wr_en_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  output logic        card_clk_o,
  output logic        drv_clk_o,
  output logic        smp_clk_o
);

  cfg_t                       cfg;
  logic                       run;
  logic                       card_nxt;
  logic [NTAPS-1:0]           inv;
  logic [NTAPS-1:0][PH_W-1:0] dly;
  logic [NTAPS-1:0]           taps;

  clkph_ctrl_reg u_reg (
    .clk_i   (par_clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_wr_en_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  clkph_div_core u_core (
    .clk_i      (par_clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .run_o      (run),
    .card_nxt_o (card_nxt),
    .card_o     (card_clk_o),
    .inv_o      (inv),
    .dly_o      (dly)
  );

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    clkph_tap u_tap (
      .clk_i      (par_clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run),
      .card_nxt_i (card_nxt),
      .inv_i      (inv[t]),
      .dly_i      (dly[t]),
      .tap_o      (taps[t])
    );
  end

  assign drv_clk_o = taps[0];
  assign smp_clk_o = taps[1];

  // R1: all outputs low in the first cycle after reset release
  assert_reset_quiet_R1: assert property (@(posedge par_clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !(card_clk_o || drv_clk_o || smp_clk_o));

endmodule

// File: tb/cardclk_phase_gen_tb_top.sv
module cardclk_phase_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        card, drv, smp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [2:0] exp_q[$];
  string    tag_q[$];

  always #4 clk = ~clk;

  cardclk_phase_gen dut_i (
    .par_clk_i   (clk),
    .rst_ni      (rst_n),
    .cfg_wr_en_i (wr_en),
    .cfg_wdata_i (wdata),
    .cfg_rdata_o (rdata),
    .card_clk_o  (card),
    .drv_clk_o   (drv),
    .smp_clk_o   (smp)
  );

  // Expected card level k cycles into a run of ratio r (R2, R3)
  function automatic bit card_at(int k, int r);
    if (k < 0) return 1'b0;
    return (k % r) < ((r + 1) / 2);
  endfunction

  // Expected companion level at sample j (R4, R5, R6)
  function automatic bit comp_at(int j, int code, int r);
    int d;
    if (code == 0) return (j == 0) ? 1'b0 : !card_at(j - 1, r);
    d = code % r;
    return card_at(j - 1 - d, r);
  endfunction

  function automatic logic [31:0] mk_ctrl(bit en, int f, int oc, int sc);
    logic [31:0] v;
    v = '0;
    v[31]    = en;
    v[3:0]   = 4'(f);
    v[10:8]  = 3'(oc);
    v[22:20] = 3'(sc);
    return v;
  endfunction

  task automatic check_val(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: one expected triple per cycle, 2 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit [2:0] e;
        string    t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({card, drv, smp} !== e) begin
          errors++;
          $display("FAIL %s actual card/drv/smp=%b expected=%b", t, {card, drv, smp}, e);
        end
      end
    end
  end

  task automatic write_ctrl(logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic push_zeros(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(3'b000);
      tag_q.push_back(tag);
    end
  endtask

  task automatic stop_run();
    write_ctrl(32'h0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    push_zeros(4, "R7 gated outputs low");
    drain();
  endtask

  task automatic run_case(int f, int oc, int sc, int n, string tag);
    logic [31:0] v;
    int r;
    r = f + 1;
    v = mk_ctrl(1'b1, f, oc, sc);
    write_ctrl(v);
    check_val("R8 readback", rdata, v);
    for (int j = 0; j < n; j++) begin
      exp_q.push_back({card_at(j - 1, r), comp_at(j, oc, r), comp_at(j, sc, r)});
      tag_q.push_back(tag);
    end
    drain();
    stop_run();
  endtask

  // R9: ratio 4 running, ratio 6 written mid-period
  task automatic mid_change();
    logic [31:0] v2;
    bit c;
    v2 = mk_ctrl(1'b1, 5, 0, 0);
    write_ctrl(mk_ctrl(1'b1, 3, 0, 0));
    for (int j = 0; j < 30; j++) begin
      int k;
      k = j - 1;
      if (k < 0)      c = 1'b0;
      else if (k < 8) c = card_at(k, 4);
      else            c = card_at(k - 8, 6);
      exp_q.push_back({c, (j == 0) ? 1'b0 : !c, (j == 0) ? 1'b0 : !c});
      tag_q.push_back("R9 ratio change at boundary");
    end
    repeat (5) @(posedge clk);
    write_ctrl(v2);
    check_val("R9 readback of new value", rdata, v2);
    drain();
    stop_run();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_val("R1 register after reset", rdata, 32'h0);
    push_zeros(3, "R1 outputs after reset");
    drain();
    // R2 R3 R5 R4: even ratio, drive delay 2, sample inverted
    run_case(3, 2, 0, 24, "R2 R3 R4 R5 ratio4");
    // R3 R6: odd ratio 5, drive 1, sample 7 wraps to 2
    run_case(4, 1, 7, 24, "R3 R5 R6 ratio5");
    // R6: ratio 3, drive 3 wraps to 0, sample 5 wraps to 2
    run_case(2, 3, 5, 20, "R6 ratio3 wrap");
    // R2 R4 R6: ratio 1, card constantly high
    run_case(0, 4, 0, 12, "R2 R4 R6 ratio1");
    // R2 R3 R5: ratio 16, drive 7, sample inverted
    run_case(15, 7, 0, 40, "R2 R3 R4 R5 ratio16");
    // R7 R8: unused bits read back, enable low keeps outputs quiet
    write_ctrl(32'h7ABC_DEF5);
    check_val("R8 readback of all bits", rdata, 32'h7ABC_DEF5);
    push_zeros(20, "R7 enable low keeps outputs low");
    drain();
    write_ctrl(32'h0);
    // R9
    mid_change();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule